// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global Entries

The block is a small, fully associative store of recent page translations that sits between an address requester and a page-table walker. A lookup presents a virtual page number and a read/write indication. The block answers in the same cycle with the frame number and access flags. On a miss it raises a walk request toward the walker and holds the requester stalled. The walker returns a refill, which the block installs: an entry already holding that page is reused, otherwise the lowest free slot, otherwise a round-robin victim.

Cached translations are dropped selectively. Reloading the page-table root with a new value, or an explicit flush request, removes every entry whose global flag is clear, and global entries stay. Rewriting the root with the value it already holds changes nothing. While the lazy-mode input is high, flush events are only remembered. The remembered flush is carried out when lazy mode ends.

A write that hits an entry whose dirty flag is clear is reported as a miss. This gives the walker the chance to mark the page dirty in memory and refill the entry.

Top module: `xlat_lookaside`

## Requirements
- R1: After reset no entry is valid: every lookup reports lk_hit=0 and walk_req=1, and lk_pfn reads zero.
- R2: A lookup with lk_req=1 that matches a valid entry reports lk_hit=1 in the same cycle, with that entry's frame number on lk_pfn and its flags on lk_rw and lk_us. On any miss, walk_req=1, walk_vpn equals lk_vpn, walk_write equals lk_write, and lk_pfn, lk_rw and lk_us read zero.
- R3: A refill (rf_valid=1 at a clock edge) makes the page hit from the next cycle on.
- R4: A write lookup (lk_write=1) to an entry whose dirty flag is 0 is a miss, while a read of the same entry hits. A refill for a page already held overwrites that entry, so no page is ever held twice.
- R5: A refill fills the lowest-index invalid slot. When all slots are valid it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each such replacement only.
- R6: Writing root_wdata with root_we=1, when the value differs from the held root (reset value 0), invalidates all non-global entries by the next cycle. Entries with the global flag set stay valid.
- R7: Writing the root with the value it already holds has no effect on the stored entries.
- R8: flush_req=1 at a clock edge outside lazy mode invalidates all non-global entries and keeps global ones.
- R9: While lazy_mode=1, flush events (flush_req or a root change) leave the entries untouched but are remembered. Several events fold into one. The remembered flush is applied at the first clock edge with lazy_mode=0.
- R10: When a refill and a flush take effect at the same edge, the refill is installed first and the flush then applies, so a non-global refill is gone and a global one survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup valid |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Translation found and usable this cycle |
| lk_pfn | output | PFN_W | Frame number of the hit (zero on a miss) |
| lk_rw | output | 1 | Writable flag of the hit |
| lk_us | output | 1 | User-accessible flag of the hit |
| walk_req | output | 1 | Miss: requester stalls, walker must translate |
| walk_vpn | output | VPN_W | Page number for the walker |
| walk_write | output | 1 | Missing access was a write |
| rf_valid | input | 1 | Walker delivers a translation |
| rf_vpn | input | VPN_W | Page number of the refill |
| rf_pfn | input | PFN_W | Frame number of the refill |
| rf_rw | input | 1 | Writable flag of the refill |
| rf_us | input | 1 | User-accessible flag of the refill |
| rf_dirty | input | 1 | Dirty flag of the refill |
| rf_glob | input | 1 | Global flag of the refill |
| root_we | input | 1 | Page-table root write strobe |
| root_wdata | input | ROOT_W | New root value |
| flush_req | input | 1 | Request to drop non-global entries |
| lazy_mode | input | 1 | Defer flushes while high |

## Verification
The bench builds the block with ENTRIES=4 and the default 20-bit page, frame and root widths. Four slots fill after a handful of refills, so the same run reaches the change from free-slot filling to round-robin replacement and a pointer wrap. It also reaches a mix of global and non-global entries across root changes, explicit flushes and a lazy-mode window. The corner cases are the clean-page write miss, a root rewrite with an unchanged value, and a refill that lands in the same edge as a flush.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

  // Per-entry attribute bits kept beside each translation.
  typedef struct packed {
    logic rw;  // page writable
    logic us;  // page reachable from user level
    logic d;   // page already marked dirty in memory
    logic g;   // survives context flushes
  } xlb_flags_t;

  // An entry may serve an access only if the access is a read, or the
  // page is already dirty (a clean-page write must go to the walker).
  function automatic logic entry_serves(input xlb_flags_t f, input logic is_write);
    return !is_write || f.d;
  endfunction

  // Keep only the entries that survive a context flush.
  function automatic logic [63:0] survivors(input logic [63:0] live,
                                            input logic [63:0] glob);
    return live & glob;
  endfunction

endpackage

// File: rtl/xlb_cam.sv
module xlb_cam #(
  parameter int N     = 16,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]            live,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = live[i] && (tags[i] == key);
  end

endmodule

// File: rtl/xlb_pick.sv
module xlb_pick #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         live,
  input  logic [N-1:0]         reuse,
  input  logic                 install,
  output logic [$clog2(N)-1:0] idx,
  output logic                 from_rr
);

  localparam int IW = $clog2(N);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] reuse_idx;
  logic          free_found;

  // Lowest-index free slot and index of the slot that already holds the page.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    reuse_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
      if (reuse[i]) reuse_idx = IW'(i);
    end
  end

  always_comb begin
    from_rr = 1'b0;
    if (|reuse)          idx = reuse_idx;
    else if (free_found) idx = free_idx;
    else begin
      idx     = rr_q;
      from_rr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rr_q <= '0;
    else if (install && from_rr) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R4: a page is never held by two slots.
  p_reuse_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reuse));

  // R5: with a free slot and no reuse, the chosen slot is free.
  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !(|reuse) && !(&live)) |-> !live[idx]);

  // R5: the round-robin pointer only moves on a replacement of a live slot.
  p_rr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(install && from_rr) |=> $stable(rr_q));

endmodule

// File: rtl/xlb_flush_ctl.sv
module xlb_flush_ctl #(
  parameter int ROOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [ROOT_W-1:0] root_wdata,
  input  logic              flush_req,
  input  logic              lazy_mode,
  output logic              flush_now,
  output logic              pend,
  output logic [ROOT_W-1:0] root_cur
);

  logic [ROOT_W-1:0] root_q;
  logic              pend_q;
  logic              root_moved;
  logic              flush_evt;

  assign root_moved = root_we && (root_wdata != root_q);
  assign flush_evt  = flush_req || root_moved;
  assign flush_now  = !lazy_mode && (flush_evt || pend_q);
  assign pend       = pend_q;
  assign root_cur   = root_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (root_we) root_q <= root_wdata;
      pend_q <= lazy_mode ? (pend_q || flush_evt) : 1'b0;
    end
  end

  // R7: the held root follows every write.
  p_root_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    root_we |=> root_q == $past(root_wdata));

  // R9: an event seen in lazy mode is still remembered on the next cycle.
  p_lazy_remember_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lazy_mode && flush_evt) |=> pend_q);

endmodule

// File: rtl/xlat_lookaside.sv
module xlat_lookaside
  import xlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ROOT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_rw,
  output logic              lk_us,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic              walk_write,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic              rf_rw,
  input  logic              rf_us,
  input  logic              rf_dirty,
  input  logic              rf_glob,
  input  logic              root_we,
  input  logic [ROOT_W-1:0] root_wdata,
  input  logic              flush_req,
  input  logic              lazy_mode
);

  localparam int IW = $clog2(ENTRIES);

  // Entry storage.
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  xlb_flags_t [ENTRIES-1:0]       flags_q;

  // Named internal events.
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] lk_usable;
  logic [ENTRIES-1:0] rf_match;
  logic [ENTRIES-1:0] glob_vec;
  logic [ENTRIES-1:0] glob_next;
  logic [ENTRIES-1:0] valid_d;
  logic [IW-1:0]      pick_idx;
  logic               pick_rr;
  logic               flush_now;
  logic               flush_pend;
  logic [ROOT_W-1:0]  root_cur;
  xlb_flags_t         rf_flags;

  assign rf_flags = '{rw: rf_rw, us: rf_us, d: rf_dirty, g: rf_glob};

  xlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .live(valid_q), .tags(vpn_q), .key(lk_vpn), .match(lk_match)
  );

  xlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_rf_cam (
    .live(valid_q), .tags(vpn_q), .key(rf_vpn), .match(rf_match)
  );

  xlb_pick #(.N(ENTRIES)) u_pick (
    .clk(clk), .rst_n(rst_n), .live(valid_q), .reuse(rf_match),
    .install(rf_valid), .idx(pick_idx), .from_rr(pick_rr)
  );

  xlb_flush_ctl #(.ROOT_W(ROOT_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .flush_req(flush_req), .lazy_mode(lazy_mode), .flush_now(flush_now),
    .pend(flush_pend), .root_cur(root_cur)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign glob_vec[i]  = flags_q[i].g;
    assign lk_usable[i] = lk_match[i] && entry_serves(flags_q[i], lk_write);
  end

  // Lookup result: at most one slot matches, so an OR-mux is enough.
  always_comb begin
    lk_hit = lk_req && (|lk_usable);
    lk_pfn = '0;
    lk_rw  = 1'b0;
    lk_us  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_req && lk_usable[i]) begin
        lk_pfn = lk_pfn | pfn_q[i];
        lk_rw  = lk_rw  | flags_q[i].rw;
        lk_us  = lk_us  | flags_q[i].us;
      end
    end
  end

  assign walk_req   = lk_req && !lk_hit;
  assign walk_vpn   = lk_vpn;
  assign walk_write = lk_write;

  // Next valid vector: install first, then apply a flush on top of it.
  always_comb begin
    valid_d   = valid_q;
    glob_next = glob_vec;
    if (rf_valid) begin
      valid_d[pick_idx]   = 1'b1;
      glob_next[pick_idx] = rf_glob;
    end
    if (flush_now)
      valid_d = ENTRIES'(survivors(64'(valid_d), 64'(glob_next)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (rf_valid) begin
      vpn_q[pick_idx]   <= rf_vpn;
      pfn_q[pick_idx]   <= rf_pfn;
      flags_q[pick_idx] <= rf_flags;
    end
  end

  // R3: a refill that no flush removes is present next cycle.
  p_refill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && (!flush_now || rf_glob)) |=>
      (valid_q[$past(pick_idx)] && vpn_q[$past(pick_idx)] == $past(rf_vpn)));

  // R6: after a flush no non-global entry remains.
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> !(|(valid_q & ~glob_vec)));

  // R6: a flush without a refill keeps every global entry.
  p_global_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_now && !rf_valid) |=> ((valid_q & glob_vec) == $past(valid_q & glob_vec)));

  // R7: rewriting the held root leaves the entries alone.
  p_same_root_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (root_we && root_wdata == root_cur && !flush_req && !rf_valid &&
     !(flush_pend && !lazy_mode)) |=> $stable(valid_q));

  // R9: nothing is dropped while lazy mode holds.
  p_lazy_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lazy_mode && !rf_valid) |=> $stable(valid_q));

  // R2: a miss always reaches the walker.
  p_miss_walks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !(|lk_usable)) |-> (walk_req && lk_pfn == '0));

endmodule

// File: tb/sim_xlat_lookaside.sv
module sim_xlat_lookaside;

  localparam int N  = 4;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int RW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_req = 1'b0, lk_write = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_hit, lk_rw, lk_us, walk_req, walk_write;
  logic [PW-1:0] lk_pfn;
  logic [VW-1:0] walk_vpn;
  logic          rf_valid = 1'b0, rf_rw = 1'b0, rf_us = 1'b0, rf_dirty = 1'b0, rf_glob = 1'b0;
  logic [VW-1:0] rf_vpn = '0;
  logic [PW-1:0] rf_pfn = '0;
  logic          root_we = 1'b0, flush_req = 1'b0, lazy_mode = 1'b0;
  logic [RW-1:0] root_wdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xlat_lookaside #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ROOT_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rw(lk_rw), .lk_us(lk_us),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_write(walk_write),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_rw(rf_rw), .rf_us(rf_us),
    .rf_dirty(rf_dirty), .rf_glob(rf_glob), .root_we(root_we), .root_wdata(root_wdata),
    .flush_req(flush_req), .lazy_mode(lazy_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a lookup in the current cycle and check the combinational answer.
  task automatic probe(input logic [VW-1:0] vpn, input logic wr, input logic hit,
                       input logic [PW-1:0] pfn, input logic rw, input logic us,
                       input string tag);
    lk_req = 1'b1; lk_vpn = vpn; lk_write = wr;
    #2;
    chk(lk_hit == hit, {tag, " hit"}, 32'(lk_hit), 32'(hit));
    chk(walk_req == !hit, {tag, " walk_req"}, 32'(walk_req), 32'(!hit));
    chk(lk_pfn == (hit ? pfn : '0), {tag, " pfn"}, 32'(lk_pfn), 32'(hit ? pfn : '0));
    if (hit) begin
      chk({lk_rw, lk_us} == {rw, us}, {tag, " flags"}, 32'({lk_rw, lk_us}), 32'({rw, us}));
    end else begin
      chk(walk_vpn == vpn && walk_write == wr, {tag, " walk info"},
          32'({walk_write, walk_vpn}), 32'({wr, vpn}));
    end
    lk_req = 1'b0;
  endtask

  task automatic look(input logic [VW-1:0] vpn, input logic wr, input logic hit,
                      input logic [PW-1:0] pfn, input logic rw, input logic us,
                      input string tag);
    @(negedge clk);
    probe(vpn, wr, hit, pfn, rw, us, tag);
  endtask

  task automatic refill(input logic [VW-1:0] vpn, input logic [PW-1:0] pfn,
                        input logic rw, input logic us, input logic d, input logic g,
                        input logic fl);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn;
    rf_rw = rw; rf_us = us; rf_dirty = d; rf_glob = g; flush_req = fl;
    @(negedge clk);
    rf_valid = 1'b0; flush_req = 1'b0;
  endtask

  task automatic write_root(input logic [RW-1:0] v);
    @(negedge clk);
    root_we = 1'b1; root_wdata = v;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  // Lookup table after the first three refills:
  // {vpn[20], write, hit, pfn[20], rw, us}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {20'h00010, 1'b0, 1'b1, 20'h0A010, 1'b1, 1'b0},  // R2 R3 read hit
    {20'h00010, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0},  // R4 clean-page write misses
    {20'h00020, 1'b0, 1'b1, 20'h0B020, 1'b0, 1'b1},  // R2 read hit
    {20'h00030, 1'b1, 1'b1, 20'h0C030, 1'b1, 1'b1},  // R2 dirty write hit
    {20'h00040, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0},  // R2 unknown page
    {20'h00020, 1'b1, 1'b1, 20'h0B020, 1'b0, 1'b1},  // R4 dirty write hit
    {20'h00031, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}   // R2 neighbouring page
  };

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(20'h00000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 reset vpn0");
    look(20'h12345, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 reset write");

    // Fill three slots: A (clean, local), B (global), C (local)
    refill(20'h00010, 20'h0A010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    refill(20'h00020, 20'h0B020, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    refill(20'h00030, 20'h0C030, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][43:24], VEC[i][23], VEC[i][22], VEC[i][21:2], VEC[i][1], VEC[i][0],
           $sformatf("R2 vector %0d", i));
    end

    // R4: refill of a held page overwrites it (slot 0 keeps it, no duplicate)
    refill(20'h00010, 20'h0A011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    look(20'h00010, 1'b1, 1'b1, 20'h0A011, 1'b1, 1'b0, "R4 overwrite write hit");

    // R5: D fills last free slot 3; then E replaces slot 0, F replaces slot 1
    refill(20'h00040, 20'h0D040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    refill(20'h00050, 20'h0E050, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    look(20'h00010, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 slot0 replaced first");
    look(20'h00020, 1'b0, 1'b1, 20'h0B020, 1'b0, 1'b1, "R5 slot1 kept");
    refill(20'h00060, 20'h0F060, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    look(20'h00020, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 slot1 replaced second");
    look(20'h00030, 1'b0, 1'b1, 20'h0C030, 1'b1, 1'b1, "R5 slot2 kept");
    look(20'h00050, 1'b0, 1'b1, 20'h0E050, 1'b1, 1'b1, "R3 E present");
    look(20'h00060, 1'b0, 1'b1, 20'h0F060, 1'b0, 1'b0, "R3 F present");

    // R7: same root (reset value 0) keeps everything
    write_root(20'h00000);
    look(20'h00050, 1'b0, 1'b1, 20'h0E050, 1'b1, 1'b1, "R7 same root keeps E");
    look(20'h00030, 1'b0, 1'b1, 20'h0C030, 1'b1, 1'b1, "R7 same root keeps C");

    // R6: new root drops local E, C; keeps global D, F
    write_root(20'h00123);
    look(20'h00050, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 E flushed");
    look(20'h00030, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 C flushed");
    look(20'h00040, 1'b0, 1'b1, 20'h0D040, 1'b1, 1'b0, "R6 D global kept");
    look(20'h00060, 1'b0, 1'b1, 20'h0F060, 1'b0, 1'b0, "R6 F global kept");

    // R5: free slots 0 and 2 fill lowest first, then pointer (at 2) replaces C
    refill(20'h00050, 20'h0E050, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00030, 20'h0C030, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00090, 20'h09090, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    look(20'h00030, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 pointer slot2 replaced");
    look(20'h00050, 1'b0, 1'b1, 20'h0E050, 1'b1, 1'b1, "R5 slot0 E kept");
    look(20'h00090, 1'b0, 1'b1, 20'h09090, 1'b1, 1'b0, "R5 X present");

    // R8: explicit flush
    pulse_flush();
    look(20'h00050, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8 E flushed");
    look(20'h00090, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8 X flushed");
    look(20'h00040, 1'b0, 1'b1, 20'h0D040, 1'b1, 1'b0, "R8 D kept");

    // R9: deferred flush in lazy mode
    refill(20'h00050, 20'h0E050, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    refill(20'h00030, 20'h0C030, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); lazy_mode = 1'b1;
    pulse_flush();
    write_root(20'h00456);
    look(20'h00050, 1'b0, 1'b1, 20'h0E050, 1'b1, 1'b1, "R9 lazy keeps E");
    look(20'h00030, 1'b0, 1'b1, 20'h0C030, 1'b1, 1'b1, "R9 lazy keeps C");
    @(negedge clk); lazy_mode = 1'b0;
    probe(20'h00030, 1'b0, 1'b1, 20'h0C030, 1'b1, 1'b1, "R9 before exit edge");
    look(20'h00030, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 C flushed on exit");
    look(20'h00050, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 E flushed on exit");
    look(20'h00060, 1'b0, 1'b1, 20'h0F060, 1'b0, 1'b0, "R9 F kept");

    // R10: refill and flush at the same edge
    refill(20'h00070, 20'h07070, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    look(20'h00070, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 local refill dropped");
    refill(20'h00080, 20'h08080, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h00080, 1'b0, 1'b1, 20'h08080, 1'b1, 1'b1, "R10 global refill kept");
    look(20'h00040, 1'b0, 1'b1, 20'h0D040, 1'b1, 1'b0, "R10 D kept");

    // R1: reset mid-run empties the buffer
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(20'h00040, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 reset clears D");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule